// File: doc/BRIEF.md
# CPU Working Register File

This block is the general-purpose register storage of a small 8-bit RISC core. It holds thirty-two 8-bit registers. Two combinational read ports supply the operands for an instruction. One write port takes back either a single result byte or a 16-bit result, which lands in an aligned pair of registers. A third, 16-bit read port returns any aligned pair in one access. All of this lets one clock cycle read two operands and write the result.

The six highest registers also serve as three 16-bit address pointers, called X, Y and Z here. A dedicated pointer port reads the selected pointer, loads it, or steps it for post-increment or pre-decrement addressing. It also produces the effective address for the memory access. The Z pointer is always presented on its own output, for use as the address of a lookup-table fetch from program memory. When a pointer update and a register-port write land on the same bytes in one cycle, the pointer update wins.

Top module: `gpr_file`

## Requirements
- R1: When `rst` is high at a rising clock edge, all 32 registers become zero.
- R2: `rd_a_data` and `rd_b_data` return, in the same cycle and independently, the contents of the registers selected by `rd_a_sel` and `rd_b_sel`.
- R3: With `wr_en`=1 and `wr_wide`=0, `wr_data[7:0]` is stored into register `wr_sel` at the rising edge, and no other register changes.
- R4: A read of a register that is being written in the same cycle returns the value it held before the edge.
- R5: With `wr_en`=1 and `wr_wide`=1, `wr_data[7:0]` goes to the even register `{wr_sel[4:1],0}` and `wr_data[15:8]` goes to the odd register `{wr_sel[4:1],1}`. `wr_sel[0]` is ignored.
- R6: `pair_data` is `{reg[2k+1], reg[2k]}` with k = `pair_sel`.
- R7: `ptr_sel` code 0 selects pointer X (registers 27:26), code 1 selects Y (29:28) and code 2 selects Z (31:30), with the low byte in the lower-numbered register. `ptr_rd_data` shows the selected pointer combinationally. Code 3 reads as zero, drives `ptr_addr` to zero and updates nothing.
- R8: `ptr_op` encodings are as follows. 0 holds the pointer. 1 loads `ptr_wr_data`. 2 is post-increment: `ptr_addr` is the old value and the pointer becomes old+1. 3 is pre-decrement: `ptr_addr` and the new pointer are both old−1. Arithmetic wraps modulo 2^16. For codes 0 and 1, `ptr_addr` is the old value.
- R9: A pointer update (`ptr_op` 1–3 on a valid pointer) overrides any register-port write to either byte of that pointer in the same cycle. Register-port bytes outside that pointer are still written.
- R10: `tbl_addr` always equals the Z pointer, `{reg[31], reg[30]}`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| rd_a_sel | input | 5 | Register index for read port A |
| rd_a_data | output | 8 | Read port A data |
| rd_b_sel | input | 5 | Register index for read port B |
| rd_b_data | output | 8 | Read port B data |
| pair_sel | input | 4 | Pair index for the 16-bit read port |
| pair_data | output | 16 | Selected register pair, odd register in the high byte |
| wr_en | input | 1 | Write port enable |
| wr_wide | input | 1 | 1: 16-bit pair write, 0: byte write |
| wr_sel | input | 5 | Destination register index |
| wr_data | input | 16 | Write data (only the low byte is used for byte writes) |
| ptr_sel | input | 2 | Pointer select: 0 X, 1 Y, 2 Z, 3 none |
| ptr_op | input | 2 | Pointer operation: 0 hold, 1 load, 2 post-increment, 3 pre-decrement |
| ptr_wr_data | input | 16 | Value for a pointer load |
| ptr_rd_data | output | 16 | Current value of the selected pointer |
| ptr_addr | output | 16 | Effective address for the pointer access |
| tbl_addr | output | 16 | Z pointer, for program-memory table lookup |

## Verification
The assertions assume that `rst` is a clean 0 or 1 at every edge. They also assume that the write and pointer controls are known (never X) whenever reset is low. The write-landing properties additionally rely on a pointer update being flagged only for valid pointer codes. The bench drives every input from a defined value at each falling edge. It holds reset for several cycles at the start and once in the middle of the run. Its random stimulus is weighted toward the top eight registers and the pointer port, so that pointer clashes and wrap-around occur often without ever leaving the legal encodings.

// File: rtl/gpr_pkg.sv
package gpr_pkg;

  typedef enum logic [1:0] {
    PTR_HOLD    = 2'd0,
    PTR_LOAD    = 2'd1,
    PTR_POSTINC = 2'd2,
    PTR_PREDEC  = 2'd3
  } ptr_op_e;

endpackage

// File: rtl/gpr_bank.sv
module gpr_bank #(
  parameter int NREGS = 32,
  parameter int DW    = 8
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [NREGS-1:0]          we,
  input  logic [NREGS-1:0][DW-1:0]  wd,
  output logic [NREGS-1:0][DW-1:0]  q
);

  for (genvar r = 0; r < NREGS; r++) begin : g_cell
    always_ff @(posedge clk) begin
      if (rst)
        q[r] <= '0;
      else if (we[r])
        q[r] <= wd[r];
    end
  end

endmodule

// File: rtl/gpr_ptr_unit.sv
module gpr_ptr_unit
  import gpr_pkg::*;
#(
  parameter int NREGS = 32,
  parameter int DW    = 8,
  parameter int NPTR  = 3,
  localparam int PW       = 2 * DW,
  localparam int PSW      = $clog2(NPTR + 1),
  localparam int PTR_BASE = NREGS - 2 * NPTR
) (
  input  logic [NREGS-1:0][DW-1:0] bank_q,
  input  logic [PSW-1:0]           ptr_sel,
  input  ptr_op_e                  ptr_op,
  input  logic [PW-1:0]            ptr_wr_data,
  output logic [PW-1:0]            ptr_cur,
  output logic [PW-1:0]            ptr_new,
  output logic [PW-1:0]            ptr_addr,
  output logic                     ptr_upd
);

  function automatic logic [PW-1:0] next_value(ptr_op_e op, logic [PW-1:0] cur,
                                                logic [PW-1:0] ld);
    case (op)
      PTR_LOAD:    return ld;
      PTR_POSTINC: return cur + PW'(1);
      PTR_PREDEC:  return cur - PW'(1);
      default:     return cur;
    endcase
  endfunction

  function automatic logic [PW-1:0] access_addr(ptr_op_e op, logic [PW-1:0] cur);
    return (op == PTR_PREDEC) ? cur - PW'(1) : cur;
  endfunction

  logic sel_ok;
  assign sel_ok = (ptr_sel < PSW'(NPTR));

  always_comb begin
    ptr_cur = '0;
    for (int p = 0; p < NPTR; p++)
      if (ptr_sel == PSW'(p))
        ptr_cur = {bank_q[PTR_BASE + 2*p + 1], bank_q[PTR_BASE + 2*p]};
  end

  assign ptr_new  = next_value(ptr_op, ptr_cur, ptr_wr_data);
  assign ptr_addr = sel_ok ? access_addr(ptr_op, ptr_cur) : '0;
  assign ptr_upd  = sel_ok && (ptr_op != PTR_HOLD);

endmodule

// File: rtl/gpr_wr_route.sv
module gpr_wr_route #(
  parameter int NREGS = 32,
  parameter int DW    = 8,
  parameter int NPTR  = 3,
  localparam int AW       = $clog2(NREGS),
  localparam int PW       = 2 * DW,
  localparam int PSW      = $clog2(NPTR + 1),
  localparam int PTR_BASE = NREGS - 2 * NPTR
) (
  input  logic                     wr_en,
  input  logic                     wr_wide,
  input  logic [AW-1:0]            wr_sel,
  input  logic [PW-1:0]            wr_data,
  input  logic                     ptr_upd,
  input  logic [PSW-1:0]           ptr_sel,
  input  logic [PW-1:0]            ptr_new,
  output logic [NREGS-1:0]         we,
  output logic [NREGS-1:0][DW-1:0] wd
);

  for (genvar r = 0; r < NREGS; r++) begin : g_reg
    localparam logic [AW-1:0] RIDX = AW'(r);
    logic          port_hit;
    logic          ptr_own;
    logic [DW-1:0] port_byte;
    logic [DW-1:0] ptr_byte;

    assign port_hit  = wr_en && (wr_wide ? (wr_sel[AW-1:1] == RIDX[AW-1:1])
                                         : (wr_sel == RIDX));
    assign port_byte = (wr_wide && RIDX[0]) ? wr_data[PW-1:DW] : wr_data[DW-1:0];
    assign ptr_byte  = RIDX[0] ? ptr_new[PW-1:DW] : ptr_new[DW-1:0];

    if (r >= PTR_BASE) begin : g_ptr
      assign ptr_own = ptr_upd && (ptr_sel == PSW'((r - PTR_BASE) / 2));
    end else begin : g_plain
      assign ptr_own = 1'b0;
    end

    assign we[r] = port_hit | ptr_own;
    assign wd[r] = ptr_own ? ptr_byte : port_byte;
  end

endmodule

// File: rtl/gpr_file.sv
module gpr_file
  import gpr_pkg::*;
#(
  parameter int NREGS = 32,
  parameter int DW    = 8,
  parameter int NPTR  = 3,
  localparam int AW  = $clog2(NREGS),
  localparam int PW  = 2 * DW,
  localparam int PSW = $clog2(NPTR + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] rd_a_sel,
  output logic [DW-1:0] rd_a_data,
  input  logic [AW-1:0] rd_b_sel,
  output logic [DW-1:0] rd_b_data,
  input  logic [AW-2:0] pair_sel,
  output logic [PW-1:0] pair_data,
  input  logic          wr_en,
  input  logic          wr_wide,
  input  logic [AW-1:0] wr_sel,
  input  logic [PW-1:0] wr_data,
  input  logic [PSW-1:0] ptr_sel,
  input  logic [1:0]    ptr_op,
  input  logic [PW-1:0] ptr_wr_data,
  output logic [PW-1:0] ptr_rd_data,
  output logic [PW-1:0] ptr_addr,
  output logic [PW-1:0] tbl_addr
);

  localparam int PTR_BASE = NREGS - 2 * NPTR;

  logic [NREGS-1:0][DW-1:0] bank_q;
  logic [NREGS-1:0][DW-1:0] bank_wd;
  logic [NREGS-1:0]         bank_we;
  logic [PW-1:0]            ptr_cur;
  logic [PW-1:0]            ptr_new;
  logic                     ptr_upd;
  ptr_op_e                  ptr_op_t;

  // Named events for the checker
  logic                     port_byte_ev;
  logic                     port_wide_ev;
  logic                     ptr_clash;
  logic [AW-2:0]            ptr_pair_idx;

  assign ptr_op_t = ptr_op_e'(ptr_op);

  gpr_bank #(.NREGS(NREGS), .DW(DW)) i_bank (
    .clk (clk),
    .rst (rst),
    .we  (bank_we),
    .wd  (bank_wd),
    .q   (bank_q)
  );

  gpr_ptr_unit #(.NREGS(NREGS), .DW(DW), .NPTR(NPTR)) i_ptr (
    .bank_q      (bank_q),
    .ptr_sel     (ptr_sel),
    .ptr_op      (ptr_op_t),
    .ptr_wr_data (ptr_wr_data),
    .ptr_cur     (ptr_cur),
    .ptr_new     (ptr_new),
    .ptr_addr    (ptr_addr),
    .ptr_upd     (ptr_upd)
  );

  gpr_wr_route #(.NREGS(NREGS), .DW(DW), .NPTR(NPTR)) i_route (
    .wr_en   (wr_en),
    .wr_wide (wr_wide),
    .wr_sel  (wr_sel),
    .wr_data (wr_data),
    .ptr_upd (ptr_upd),
    .ptr_sel (ptr_sel),
    .ptr_new (ptr_new),
    .we      (bank_we),
    .wd      (bank_wd)
  );

  assign rd_a_data   = bank_q[rd_a_sel];
  assign rd_b_data   = bank_q[rd_b_sel];
  assign pair_data   = {bank_q[{pair_sel, 1'b1}], bank_q[{pair_sel, 1'b0}]};
  assign ptr_rd_data = ptr_cur;
  assign tbl_addr    = {bank_q[NREGS-1], bank_q[NREGS-2]};

  assign port_byte_ev = wr_en && !wr_wide;
  assign port_wide_ev = wr_en && wr_wide;
  assign ptr_pair_idx = (AW-1)'(PTR_BASE / 2) + (AW-1)'(ptr_sel);
  assign ptr_clash    = ptr_upd && wr_en && (wr_sel[AW-1:1] == ptr_pair_idx);

endmodule

// File: rtl/gpr_file_chk.sv
module gpr_file_chk #(
  parameter int NREGS = 32,
  parameter int DW    = 8,
  parameter int NPTR  = 3,
  localparam int AW       = $clog2(NREGS),
  localparam int PW       = 2 * DW,
  localparam int PSW      = $clog2(NPTR + 1),
  localparam int PTR_BASE = NREGS - 2 * NPTR
) (
  input logic                     clk,
  input logic                     rst,
  input logic [NREGS-1:0][DW-1:0] bank_q,
  input logic                     port_byte_ev,
  input logic                     port_wide_ev,
  input logic                     ptr_clash,
  input logic                     ptr_upd,
  input logic [AW-1:0]            wr_sel,
  input logic [PW-1:0]            wr_data,
  input logic [PSW-1:0]           ptr_sel,
  input logic [1:0]               ptr_op,
  input logic [PW-1:0]            ptr_wr_data,
  input logic [PW-1:0]            ptr_addr
);

  function automatic logic [PW-1:0] ptr_of(logic [NREGS-1:0][DW-1:0] q, logic [PSW-1:0] s);
    return {q[PTR_BASE + 2*int'(s) + 1], q[PTR_BASE + 2*int'(s)]};
  endfunction

  assert_reset_clears_R1: assert property (@(posedge clk)
    rst |=> bank_q == '0);

  assert_byte_lands_R3: assert property (@(posedge clk) disable iff (rst)
    port_byte_ev && !ptr_clash |=> bank_q[$past(wr_sel)] == $past(wr_data[DW-1:0]));

  assert_pair_lands_R5: assert property (@(posedge clk) disable iff (rst)
    port_wide_ev && !ptr_clash |=>
      {bank_q[{$past(wr_sel[AW-1:1]), 1'b1}], bank_q[{$past(wr_sel[AW-1:1]), 1'b0}]}
        == $past(wr_data));

  assert_ptr_load_R8: assert property (@(posedge clk) disable iff (rst)
    ptr_upd && ptr_op == 2'd1 |=> ptr_of(bank_q, $past(ptr_sel)) == $past(ptr_wr_data));

  assert_ptr_postinc_R8: assert property (@(posedge clk) disable iff (rst)
    ptr_upd && ptr_op == 2'd2 |=> ptr_of(bank_q, $past(ptr_sel)) == PW'($past(ptr_addr) + PW'(1)));

  assert_ptr_predec_R8: assert property (@(posedge clk) disable iff (rst)
    ptr_upd && ptr_op == 2'd3 |=> ptr_of(bank_q, $past(ptr_sel)) == $past(ptr_addr));

  // R9: a clashing pointer update still lands its own value
  assert_ptr_wins_R9: assert property (@(posedge clk) disable iff (rst)
    ptr_clash && ptr_op == 2'd1 |=> ptr_of(bank_q, $past(ptr_sel)) == $past(ptr_wr_data));

  assert_idle_stable_R3: assert property (@(posedge clk) disable iff (rst)
    !port_byte_ev && !port_wide_ev && !ptr_upd |=> $stable(bank_q));

endmodule

bind gpr_file gpr_file_chk #(.NREGS(NREGS), .DW(DW), .NPTR(NPTR)) i_chk (
  .clk          (clk),
  .rst          (rst),
  .bank_q       (bank_q),
  .port_byte_ev (port_byte_ev),
  .port_wide_ev (port_wide_ev),
  .ptr_clash    (ptr_clash),
  .ptr_upd      (ptr_upd),
  .wr_sel       (wr_sel),
  .wr_data      (wr_data),
  .ptr_sel      (ptr_sel),
  .ptr_op       (ptr_op),
  .ptr_wr_data  (ptr_wr_data),
  .ptr_addr     (ptr_addr)
);

// File: tb/test_gpr_file.sv
`timescale 1ns/1ps
module test_gpr_file;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [4:0]  rd_a_sel = '0, rd_b_sel = '0, wr_sel = '0;
  logic [7:0]  rd_a_data, rd_b_data;
  logic [3:0]  pair_sel = '0;
  logic [15:0] pair_data, wr_data = '0, ptr_wr_data = '0;
  logic        wr_en = 1'b0, wr_wide = 1'b0;
  logic [1:0]  ptr_sel = 2'd3, ptr_op = 2'd0;
  logic [15:0] ptr_rd_data, ptr_addr, tbl_addr;

  int errors = 0;
  int checks = 0;
  bit done = 0;
  logic [7:0] m [32];

  always #5 clk = ~clk;

  gpr_file i_gpr_file (
    .clk(clk), .rst(rst),
    .rd_a_sel(rd_a_sel), .rd_a_data(rd_a_data),
    .rd_b_sel(rd_b_sel), .rd_b_data(rd_b_data),
    .pair_sel(pair_sel), .pair_data(pair_data),
    .wr_en(wr_en), .wr_wide(wr_wide), .wr_sel(wr_sel), .wr_data(wr_data),
    .ptr_sel(ptr_sel), .ptr_op(ptr_op), .ptr_wr_data(ptr_wr_data),
    .ptr_rd_data(ptr_rd_data), .ptr_addr(ptr_addr), .tbl_addr(tbl_addr)
  );

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int model_ptr(int s);
    if (s > 2) return 0;
    return {m[27 + 2*s], m[26 + 2*s]};
  endfunction

  // Reference update applied at each rising edge from the inputs then held
  task automatic model_edge();
    logic [7:0] n [32];
    int cur, nv, s;
    n = m;
    if (rst) begin
      foreach (n[i]) n[i] = 8'h00;
    end else begin
      if (wr_en) begin
        if (wr_wide) begin
          n[{wr_sel[4:1], 1'b0}] = wr_data[7:0];
          n[{wr_sel[4:1], 1'b1}] = wr_data[15:8];
        end else
          n[wr_sel] = wr_data[7:0];
      end
      s = int'(ptr_sel);
      if (s < 3 && ptr_op != 2'd0) begin
        cur = model_ptr(s);
        case (ptr_op)
          2'd1: nv = int'(ptr_wr_data);
          2'd2: nv = (cur + 1) % 65536;
          default: nv = (cur + 65535) % 65536;
        endcase
        n[26 + 2*s] = nv[7:0];
        n[27 + 2*s] = nv[15:8];
      end
    end
    m = n;
  endtask

  task automatic tick();
    @(posedge clk);
    model_edge();
    @(negedge clk);
  endtask

  task automatic compare_all();
    int s, cur, exp_addr;
    #1;
    check("R2 port A", rd_a_data, m[rd_a_sel]);
    check("R2 port B", rd_b_data, m[rd_b_sel]);
    check("R6 pair", pair_data, {m[{pair_sel, 1'b1}], m[{pair_sel, 1'b0}]});
    s = int'(ptr_sel);
    cur = model_ptr(s);
    check("R7 pointer read", ptr_rd_data, cur);
    if (s > 2) exp_addr = 0;
    else if (ptr_op == 2'd3) exp_addr = (cur + 65535) % 65536;
    else exp_addr = cur;
    check("R8 pointer address", ptr_addr, exp_addr);
    check("R10 table address", tbl_addr, model_ptr(2));
  endtask

  task automatic idle();
    wr_en = 0; wr_wide = 0; ptr_op = 2'd0; ptr_sel = 2'd3;
  endtask

  initial begin
    foreach (m[i]) m[i] = 8'hxx;
    repeat (3) tick();
    rst = 0;
    // R1: all registers zero after reset
    for (int i = 0; i < 32; i++) begin
      rd_a_sel = 5'(i);
      #1 check("R1 reset value", rd_a_data, 0);
    end

    // R3: byte write, neighbour untouched
    wr_en = 1; wr_wide = 0; wr_sel = 5'd7; wr_data = 16'hFF3C;
    rd_a_sel = 5'd7; rd_b_sel = 5'd6;
    tick(); idle();
    #1 check("R3 byte written", rd_a_data, 8'h3C);
    check("R3 neighbour unchanged", rd_b_data, 8'h00);

    // R4: same-cycle read returns old value
    wr_en = 1; wr_sel = 5'd7; wr_data = 16'h0099;
    #1 check("R4 old value during write", rd_a_data, 8'h3C);
    tick(); idle();
    #1 check("R4 new value after edge", rd_a_data, 8'h99);

    // R5: wide write with odd selector, bit 0 ignored
    wr_en = 1; wr_wide = 1; wr_sel = 5'd11; wr_data = 16'hBEEF;
    tick(); idle();
    rd_a_sel = 5'd10; rd_b_sel = 5'd11; pair_sel = 4'd5;
    #1 check("R5 low byte to even", rd_a_data, 8'hEF);
    check("R5 high byte to odd", rd_b_data, 8'hBE);
    check("R6 pair read", pair_data, 16'hBEEF);

    // R8: load, pre-decrement wrap, post-increment wrap on Y
    ptr_sel = 2'd1; ptr_op = 2'd1; ptr_wr_data = 16'h0000;
    tick();
    ptr_op = 2'd3;
    #1 check("R8 predec address", ptr_addr, 16'hFFFF);
    tick();
    ptr_op = 2'd2;
    #1 check("R8 predec result", ptr_rd_data, 16'hFFFF);
    check("R8 postinc address", ptr_addr, 16'hFFFF);
    tick(); idle(); ptr_sel = 2'd1;
    #1 check("R8 postinc wrap", ptr_rd_data, 16'h0000);

    // R9: pointer update on Z beats byte write into reg 30
    ptr_sel = 2'd2; ptr_op = 2'd1; ptr_wr_data = 16'h1234;
    tick();
    ptr_op = 2'd2; wr_en = 1; wr_wide = 0; wr_sel = 5'd30; wr_data = 16'h0055;
    tick(); idle(); ptr_sel = 2'd2;
    #1 check("R9 pointer wins", ptr_rd_data, 16'h1235);
    check("R10 table pointer", tbl_addr, 16'h1235);
    // R9: wide write into X while Y updates is still written
    ptr_sel = 2'd1; ptr_op = 2'd2; wr_en = 1; wr_wide = 1; wr_sel = 5'd26; wr_data = 16'hA1B2;
    tick(); idle();
    pair_sel = 4'd13;
    #1 check("R9 non-overlapping pair written", pair_data, 16'hA1B2);

    // R7: code 3 reads zero and updates nothing
    ptr_sel = 2'd3; ptr_op = 2'd2;
    #1 check("R7 invalid pointer reads zero", ptr_rd_data, 0);
    check("R7 invalid pointer address zero", ptr_addr, 0);
    tick(); idle();
    #1 check("R7 no update on code 3", tbl_addr, 16'h1235);

    // Random traffic compared on every clock
    for (int c = 0; c < 4000; c++) begin
      rst = (c == 2000);
      wr_en = ($urandom % 3) != 0;
      wr_wide = $urandom % 2;
      wr_sel = ($urandom % 2) ? 5'(24 + $urandom % 8) : 5'($urandom);
      wr_data = 16'($urandom);
      rd_a_sel = 5'($urandom);
      rd_b_sel = ($urandom % 2) ? wr_sel : 5'($urandom);
      pair_sel = 4'($urandom);
      ptr_sel = 2'($urandom);
      ptr_op = 2'($urandom);
      ptr_wr_data = ($urandom % 4 == 0) ? 16'hFFFF : 16'($urandom);
      compare_all();
      tick();
    end
    idle();
    compare_all();

    done = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule